// File: doc/BRIEF.md
# User-Mode Kernel-Address Access Guard

This block sits beside the first-stage address translation of a 64-bit core and stops user-level code from probing the upper (kernel) half of the virtual address space. For every translation request it decides in the same cycle whether the access must be refused with a translation fault. Page permissions play no part in that decision. Only the sign bit of the virtual address, the effective privilege of the access and two software-controlled enable bits count.

The block owns those two enable bits. One sits at bit 8 of the supervisor environment-configuration register. The other sits at bit 24 of the hypervisor status register. The CSR file forwards writes of these registers to the block, and the block returns each stored bit in its field position for read data. Which bit governs a request depends on the origin of the access. A hypervisor virtual-machine load or store issued from non-virtualized U-mode uses the hypervisor bit. Every other access uses the supervisor bit. A build parameter removes the feature, and the bits then read as zero.

Top module: `ukaddr_guard`

## Requirements
- R1: After reset both enable bits read as zero, and no request faults until software sets an enable bit.
- R2: A write to the supervisor environment-configuration register stores write-data bit 8. The supervisor read output shows the stored bit at bit 8 and zero in every other bit. A write to the hypervisor status register leaves this bit unchanged.
- R3: A write to the hypervisor status register stores write-data bit 24. The hypervisor read output shows the stored bit at bit 24 and zero in every other bit. A write to the supervisor register leaves this bit unchanged.
- R4: With the feature parameter cleared, supervisor writes leave bit 8 at its reset value of zero, hypervisor writes force bit 24 to zero, and no request ever faults.
- R5: A request can fault only when it is a first-stage translation and the 4-bit satp mode equals 8 (Sv39).
- R6: The hypervisor enable bit governs a request when the hart is in U-mode (privilege code 0), virtualization is off and the request is a hypervisor load/store. The supervisor enable bit governs every other request.
- R7: A request is checked in each of the following cases:
  - M-mode (code 3) with MPRV set and MPP equal to U (0), for a request that is not a hypervisor load/store;
  - a hypervisor load/store from HS-mode (code 1, virtualization off) with SPVP clear;
  - a plain U-mode access;
  - a VU-mode access, meaning U-mode with virtualization on;
  - a hypervisor load/store from non-virtualized U-mode with HU set.
- R8: The following requests never fault:
  - an S-mode or VS-mode access that is not a hypervisor load/store;
  - an M-mode access with MPRV clear or MPP not equal to U;
  - a hypervisor load/store from HS-mode with SPVP set;
  - a hypervisor load/store from U-mode with HU clear.
- R9: A checked and enabled request faults exactly when the address sign bit is 1. The sign bit is address bit 31 when SXL equals 1 and address bit 63 for any other SXL value.
- R10: The fault output is combinational and valid in the same cycle as the request. It is zero whenever the request-valid input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_senv_i | input | 1 | Write strobe for the supervisor environment-config register |
| csr_wr_hstat_i | input | 1 | Write strobe for the hypervisor status register |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_senv_rd_o | output | XLEN | Owned supervisor bit in its field position, other bits zero |
| csr_hstat_rd_o | output | XLEN | Owned hypervisor bit in its field position, other bits zero |
| req_valid_i | input | 1 | Translation request present |
| priv_i | input | 2 | Current hart privilege (0 U, 1 S, 3 M) |
| virt_i | input | 1 | Virtualization currently on |
| hyp_ls_i | input | 1 | Request comes from a hypervisor virtual-machine load/store |
| mprv_i | input | 1 | Modify-privilege bit of machine status |
| mpp_i | input | 2 | Machine previous privilege |
| spvp_i | input | 1 | Hypervisor previous-virtual-privilege bit |
| hu_i | input | 1 | Hypervisor-in-user enable bit |
| first_stage_i | input | 1 | Request is a first-stage translation |
| satp_mode_i | input | 4 | Translation mode field of satp |
| sxl_i | input | 2 | Supervisor XLEN code |
| vaddr_i | input | XLEN | Virtual address of the request |
| fault_o | output | 1 | Translation fault due to a kernel address under user mode |

## Verification
A wrong stored enable bit appears on the matching read output one cycle after the write that set it. It also appears on the fault output of the next checked upper-half request that this bit governs. A wrong mode or enable-source decision is internal state of the combinational path, so it shows on the fault output in the very cycle of the request. The bench therefore pairs each privilege combination with both enable settings and both address signs. A reference model compares the fault output and both read outputs on every clock.

// File: rtl/ukaddr_pkg.sv
package ukaddr_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef struct packed {
        logic sup_en;
        logic hyp_en;
    } ctl_state_t;

    localparam logic [3:0] SATP_MODE_SV39 = 4'd8;
    localparam logic [1:0] SXL_CODE_32    = 2'd1;

endpackage

// File: rtl/ukaddr_ctl_regs.sv
module ukaddr_ctl_regs
    import ukaddr_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter bit FEAT_EN   = 1'b1,
    parameter int SENV_POS  = 8,
    parameter int HSTAT_POS = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_senv_i,
    input  logic            wr_hstat_i,
    input  logic [XLEN-1:0] wdata_i,
    output logic            sup_en_o,
    output logic            hyp_en_o,
    output logic [XLEN-1:0] senv_rd_o,
    output logic [XLEN-1:0] hstat_rd_o
);

    localparam logic [XLEN-1:0] SENV_MASK  = XLEN'(1) << SENV_POS;
    localparam logic [XLEN-1:0] HSTAT_MASK = XLEN'(1) << HSTAT_POS;

    ctl_state_t state_d, state_q;
    logic       unused_wdata;

    assign unused_wdata = ^(wdata_i & ~(SENV_MASK | HSTAT_MASK));

    always_comb begin
        state_d = state_q;
        if (wr_senv_i) begin
            if (FEAT_EN) begin
                state_d.sup_en = wdata_i[SENV_POS];
            end
        end
        if (wr_hstat_i) begin
            state_d.hyp_en = FEAT_EN ? wdata_i[HSTAT_POS] : 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sup_en_o   = state_q.sup_en;
    assign hyp_en_o   = state_q.hyp_en;
    assign senv_rd_o  = state_q.sup_en ? SENV_MASK : '0;
    assign hstat_rd_o = state_q.hyp_en ? HSTAT_MASK : '0;

    // R2: the supervisor bit moves only on a supervisor write
    p_sup_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_senv_i |=> $stable(sup_en_o));

    // R3: the hypervisor bit moves only on a hypervisor write
    p_hyp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hstat_i |=> $stable(hyp_en_o));

    generate
        if (FEAT_EN) begin : g_feat
            // R3: a hypervisor write lands in the stored bit
            p_hyp_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
                wr_hstat_i |=> (hstat_rd_o[HSTAT_POS] == $past(wdata_i[HSTAT_POS])));
        end else begin : g_nofeat
            // R4: without the feature both bits stay clear
            p_bits_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
                !sup_en_o && !hyp_en_o);
        end
    endgenerate

endmodule

// File: rtl/ukaddr_mode_eval.sv
module ukaddr_mode_eval
    import ukaddr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] priv_i,
    input  logic       virt_i,
    input  logic       hyp_ls_i,
    input  logic       mprv_i,
    input  logic [1:0] mpp_i,
    input  logic       spvp_i,
    input  logic       hu_i,
    input  logic       sup_en_i,
    input  logic       hyp_en_i,
    output logic       eff_user_o,
    output logic       enable_o
);

    priv_e cur_priv;
    priv_e prev_priv;
    logic  m_as_user;
    logic  hs_hyp_user;
    logic  plain_user;
    logic  u_hyp_user;
    logic  use_hyp_en;

    assign cur_priv  = priv_e'(priv_i);
    assign prev_priv = priv_e'(mpp_i);

    always_comb begin
        m_as_user   = (cur_priv == PRIV_M) && !hyp_ls_i && mprv_i && (prev_priv == PRIV_U);
        hs_hyp_user = (cur_priv == PRIV_S) && !virt_i && hyp_ls_i && !spvp_i;
        plain_user  = (cur_priv == PRIV_U) && !hyp_ls_i;
        u_hyp_user  = (cur_priv == PRIV_U) && !virt_i && hyp_ls_i && hu_i;
        use_hyp_en  = (cur_priv == PRIV_U) && !virt_i && hyp_ls_i;

        eff_user_o  = m_as_user | hs_hyp_user | plain_user | u_hyp_user;
        enable_o    = use_hyp_en ? hyp_en_i : sup_en_i;
    end

    // R7: the user paths are mutually exclusive
    p_paths_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({m_as_user, hs_hyp_user, plain_user, u_hyp_user}));

    // R8: supervisor privilege counts as user only via hypervisor accesses
    p_s_needs_hyp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_user_o && cur_priv == PRIV_S) |-> (hyp_ls_i && !spvp_i));

endmodule

// File: rtl/ukaddr_addr_chk.sv
module ukaddr_addr_chk
    import ukaddr_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [1:0]      sxl_i,
    input  logic [XLEN-1:0] vaddr_i,
    output logic            upper_half_o
);

    localparam int NARROW_MSB = XLEN / 2 - 1;
    localparam int WIDE_MSB   = XLEN - 1;

    logic unused_vaddr;

    assign unused_vaddr = ^vaddr_i;

    always_comb begin
        if (sxl_i == SXL_CODE_32) begin
            upper_half_o = vaddr_i[NARROW_MSB];
        end else begin
            upper_half_o = vaddr_i[WIDE_MSB];
        end
    end

endmodule

// File: rtl/ukaddr_guard.sv
module ukaddr_guard
    import ukaddr_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter bit FEAT_EN   = 1'b1,
    parameter int SENV_POS  = 8,
    parameter int HSTAT_POS = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            csr_wr_senv_i,
    input  logic            csr_wr_hstat_i,
    input  logic [XLEN-1:0] csr_wdata_i,
    output logic [XLEN-1:0] csr_senv_rd_o,
    output logic [XLEN-1:0] csr_hstat_rd_o,
    input  logic            req_valid_i,
    input  logic [1:0]      priv_i,
    input  logic            virt_i,
    input  logic            hyp_ls_i,
    input  logic            mprv_i,
    input  logic [1:0]      mpp_i,
    input  logic            spvp_i,
    input  logic            hu_i,
    input  logic            first_stage_i,
    input  logic [3:0]      satp_mode_i,
    input  logic [1:0]      sxl_i,
    input  logic [XLEN-1:0] vaddr_i,
    output logic            fault_o
);

    logic sup_en;
    logic hyp_en;
    logic eff_user;
    logic enable;
    logic upper_half;
    logic gate_open;

    ukaddr_ctl_regs #(
        .XLEN      (XLEN),
        .FEAT_EN   (FEAT_EN),
        .SENV_POS  (SENV_POS),
        .HSTAT_POS (HSTAT_POS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_senv_i  (csr_wr_senv_i),
        .wr_hstat_i (csr_wr_hstat_i),
        .wdata_i    (csr_wdata_i),
        .sup_en_o   (sup_en),
        .hyp_en_o   (hyp_en),
        .senv_rd_o  (csr_senv_rd_o),
        .hstat_rd_o (csr_hstat_rd_o)
    );

    ukaddr_mode_eval u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .priv_i     (priv_i),
        .virt_i     (virt_i),
        .hyp_ls_i   (hyp_ls_i),
        .mprv_i     (mprv_i),
        .mpp_i      (mpp_i),
        .spvp_i     (spvp_i),
        .hu_i       (hu_i),
        .sup_en_i   (sup_en),
        .hyp_en_i   (hyp_en),
        .eff_user_o (eff_user),
        .enable_o   (enable)
    );

    ukaddr_addr_chk #(
        .XLEN (XLEN)
    ) u_addr (
        .sxl_i        (sxl_i),
        .vaddr_i      (vaddr_i),
        .upper_half_o (upper_half)
    );

    always_comb begin
        gate_open = FEAT_EN && first_stage_i && (satp_mode_i == SATP_MODE_SV39);
        fault_o   = req_valid_i && gate_open && eff_user && enable && upper_half;
    end

    // R5: faults only under first-stage Sv39
    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (first_stage_i && satp_mode_i == SATP_MODE_SV39));

    // R10: no fault without a request
    p_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |-> !fault_o);

    // R9: wide SXL faults only on a set top address bit
    p_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && sxl_i != SXL_CODE_32) |-> vaddr_i[XLEN-1]);

    // R1: with both read outputs clear nothing faults
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_senv_rd_o == '0 && csr_hstat_rd_o == '0) |-> !fault_o);

endmodule

// File: tb/tb_ukaddr_guard.sv
module tb_ukaddr_guard;

    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_senv = 1'b0, wr_hstat = 1'b0;
    logic [XLEN-1:0] wdata = '0;
    logic [XLEN-1:0] senv_rd, hstat_rd, senv_rd_off, hstat_rd_off;
    logic            req_valid = 1'b0;
    logic [1:0]      priv = 2'd0;
    logic            virt = 1'b0, hyp_ls = 1'b0, mprv = 1'b0, spvp = 1'b0, hu = 1'b0;
    logic [1:0]      mpp = 2'd0;
    logic            first_stage = 1'b1;
    logic [3:0]      satp_mode = 4'd8;
    logic [1:0]      sxl = 2'd2;
    logic [XLEN-1:0] vaddr = '0;
    logic            fault, fault_off;

    int    checks = 0;
    int    failures = 0;
    string tag = "R1";
    bit    comparing = 1'b0;

    bit ref_sup = 1'b0;
    bit ref_hyp = 1'b0;

    always #10 clk = ~clk;

    ukaddr_guard #(.XLEN(XLEN), .FEAT_EN(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .csr_wr_senv_i(wr_senv), .csr_wr_hstat_i(wr_hstat),
        .csr_wdata_i(wdata), .csr_senv_rd_o(senv_rd), .csr_hstat_rd_o(hstat_rd),
        .req_valid_i(req_valid), .priv_i(priv), .virt_i(virt), .hyp_ls_i(hyp_ls),
        .mprv_i(mprv), .mpp_i(mpp), .spvp_i(spvp), .hu_i(hu),
        .first_stage_i(first_stage), .satp_mode_i(satp_mode), .sxl_i(sxl),
        .vaddr_i(vaddr), .fault_o(fault)
    );

    ukaddr_guard #(.XLEN(XLEN), .FEAT_EN(1'b0)) dut_off (
        .clk(clk), .rst_n(rst_n), .csr_wr_senv_i(wr_senv), .csr_wr_hstat_i(wr_hstat),
        .csr_wdata_i(wdata), .csr_senv_rd_o(senv_rd_off), .csr_hstat_rd_o(hstat_rd_off),
        .req_valid_i(req_valid), .priv_i(priv), .virt_i(virt), .hyp_ls_i(hyp_ls),
        .mprv_i(mprv), .mpp_i(mpp), .spvp_i(spvp), .hu_i(hu),
        .first_stage_i(first_stage), .satp_mode_i(satp_mode), .sxl_i(sxl),
        .vaddr_i(vaddr), .fault_o(fault_off)
    );

    // Reference model of the stored bits (R2, R3)
    always @(posedge clk) begin
        if (!rst_n) begin
            ref_sup <= 1'b0;
            ref_hyp <= 1'b0;
        end else begin
            if (wr_senv)  ref_sup <= wdata[8];
            if (wr_hstat) ref_hyp <= wdata[24];
        end
    end

    // Expected fault from the requirement text
    function automatic bit expect_fault();
        bit user_like;
        bit en;
        bit sign;
        if (!req_valid) return 1'b0;                          // R10
        if (!first_stage || satp_mode != 4'd8) return 1'b0;   // R5
        user_like = 1'b0;                                     // R7 / R8
        case (priv)
            2'd0: user_like = hyp_ls ? (!virt && hu) : 1'b1;
            2'd1: user_like = hyp_ls && !virt && !spvp;
            2'd3: user_like = !hyp_ls && mprv && (mpp == 2'd0);
            default: user_like = 1'b0;
        endcase
        en   = (priv == 2'd0 && !virt && hyp_ls) ? ref_hyp : ref_sup;  // R6
        sign = (sxl == 2'd1) ? vaddr[31] : vaddr[63];                   // R9
        return user_like && en && sign;
    endfunction

    task automatic check1(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (comparing) begin
            check1(tag, XLEN'(fault), XLEN'(expect_fault()));
            check1(tag, senv_rd, ref_sup ? (XLEN'(1) << 8) : '0);
            check1(tag, hstat_rd, ref_hyp ? (XLEN'(1) << 24) : '0);
            check1("R4", XLEN'(fault_off), '0);
            check1("R4", senv_rd_off | hstat_rd_off, '0);
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic csr_write(input bit to_senv, input logic [XLEN-1:0] val);
        wr_senv  = to_senv;
        wr_hstat = !to_senv;
        wdata    = val;
        step();
        wr_senv  = 1'b0;
        wr_hstat = 1'b0;
        wdata    = '0;
    endtask

    task automatic set_mode(input logic [1:0] p, input bit v, input bit h, input bit mp,
                            input logic [1:0] pp, input bit sp, input bit u);
        priv = p; virt = v; hyp_ls = h; mprv = mp; mpp = pp; spvp = sp; hu = u;
    endtask

    // Walk a set of mode combinations with a high and a low address
    task automatic sweep_modes();
        for (int m = 0; m < 13; m++) begin
            case (m)
                0:  set_mode(2'd0, 0, 0, 0, 2'd0, 0, 0); // U
                1:  set_mode(2'd0, 1, 0, 0, 2'd0, 0, 0); // VU
                2:  set_mode(2'd3, 0, 0, 1, 2'd0, 0, 0); // M, MPRV, MPP=U
                3:  set_mode(2'd1, 0, 1, 0, 2'd0, 0, 0); // HS hyp, SPVP=0
                4:  set_mode(2'd0, 0, 1, 0, 2'd0, 0, 1); // U hyp, HU=1
                5:  set_mode(2'd1, 0, 0, 0, 2'd0, 0, 0); // S
                6:  set_mode(2'd1, 1, 0, 0, 2'd0, 0, 0); // VS
                7:  set_mode(2'd3, 0, 0, 0, 2'd0, 0, 0); // M, MPRV=0
                8:  set_mode(2'd3, 0, 0, 1, 2'd1, 0, 0); // M, MPP=S
                9:  set_mode(2'd1, 0, 1, 0, 2'd0, 1, 0); // HS hyp, SPVP=1
                10: set_mode(2'd0, 0, 1, 0, 2'd0, 0, 0); // U hyp, HU=0
                11: set_mode(2'd3, 0, 1, 1, 2'd0, 0, 0); // M hyp with MPRV
                default: set_mode(2'd0, 1, 1, 0, 2'd0, 0, 1);
            endcase
            vaddr = 64'hFFFF_FFC0_0000_1000; step();
            vaddr = 64'h0000_0000_0040_2000; step();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        comparing = 1'b1;

        tag = "R1";
        req_valid = 1'b1;
        sweep_modes();

        tag = "R2";
        csr_write(1'b1, {XLEN{1'b1}});
        step();
        csr_write(1'b0, '0);
        step();
        csr_write(1'b1, ~(XLEN'(1) << 8));
        csr_write(1'b1, XLEN'(1) << 8);

        tag = "R3";
        csr_write(1'b0, {XLEN{1'b1}});
        csr_write(1'b1, XLEN'(1) << 8);
        csr_write(1'b0, ~(XLEN'(1) << 24));
        csr_write(1'b0, XLEN'(1) << 24);

        tag = "R7";
        sweep_modes();
        tag = "R8";
        sweep_modes();

        tag = "R6";
        csr_write(1'b1, '0);
        sweep_modes();
        csr_write(1'b1, XLEN'(1) << 8);
        csr_write(1'b0, '0);
        sweep_modes();
        csr_write(1'b0, XLEN'(1) << 24);

        tag = "R5";
        set_mode(2'd0, 0, 0, 0, 2'd0, 0, 0);
        vaddr = 64'h8000_0000_0000_0000;
        satp_mode = 4'd9; step();
        satp_mode = 4'd0; step();
        satp_mode = 4'd8; first_stage = 1'b0; step();
        first_stage = 1'b1; step();

        tag = "R9";
        sxl = 2'd1; vaddr = 64'h0000_0000_8000_0000; step();
        vaddr = 64'h8000_0000_7FFF_FFFF; step();
        sxl = 2'd2; vaddr = 64'h0000_0000_8000_0000; step();
        vaddr = 64'h8000_0000_0000_0000; step();
        sxl = 2'd3; step();
        vaddr = 64'h7FFF_FFFF_FFFF_FFFF; step();
        sxl = 2'd2;

        tag = "R10";
        vaddr = 64'hFFFF_FFFF_FFFF_FFFF;
        req_valid = 1'b0; step();
        req_valid = 1'b1; step();
        req_valid = 1'b0; step();

        comparing = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule